// File: doc/BRIEF.md
# Permuted 3D Element Index Remapper

This block generates element indices in order for a vector register pipeline. It treats the elements of a register as a three-dimensional array. Each dimension size is stored as its size minus one. A permutation selector chooses which dimension moves fastest and which moves slowest. As the pipeline walks its element numbers from zero upward, the block produces, one element per step, the real register element that each step should touch.

Software writes one 32-bit shape word and pulses `start_i`. The block then presents index 0. Each cycle in which `step_i` is high moves it on by one element. The walk uses three nested counters, nested in the selected order. The counter values are turned into a linear offset in x-major layout.

When the array holds fewer elements than the vector length, the walk wraps around and indices repeat. This is legal. A word of all zeros leaves the element numbers unchanged. A word with a reserved permutation or a reserved bit set raises a flag and also leaves the element numbers unchanged.

Top module: `elem_remap`

## Requirements
- R1: After reset, `valid_o` and `illegal_o` are 0 and `index_o` is 0.
- R2: A `start_i` pulse captures `cfg_i` and clears the walk. In the next cycle `valid_o` is 1 and `index_o` is 0. `start_i` has priority over `step_i`, and a later pulse restarts the walk.
- R3: While `valid_o` is 1 and `start_i` is 0, each cycle with `step_i` high moves the output one element on, visible after that clock edge. With `step_i` low, the output holds.
- R4: The shape word has these fields: x-size-minus-one in bits 6..0, y in bits 14..8, z in bits 22..16, and a permutation in bits 26..24. A field value v gives a dimension of v+1 elements.
- R5: The permutation selects the counting order, fastest dimension first: 0 gives x,y,z; 1 gives x,z,y; 2 gives y,x,z; 3 gives y,z,x; 4 gives z,x,y; 5 gives z,y,x.
- R6: A counter that reaches its size clears and carries into the next dimension in the order. When the slowest counter overflows, the walk returns to index 0, so indices repeat.
- R7: For every legal permutation, the output is x + y·X + z·X·Y, where X and Y are the real sizes of the x and y dimensions.
- R8: A shape word of all zeros gives the step count itself as the output. This count wraps only at the index width.
- R9: A permutation of 6 or 7, or any set bit among 7, 15, 23 and 31..27, sets `illegal_o`. The output then follows the step count, as in R8.
- R10: `step_i` has no effect before the first `start_i`: `valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture shape word and restart the walk |
| step_i | input | 1 | Advance one element |
| cfg_i | input | 32 | Shape word |
| valid_o | output | 1 | Index output is meaningful |
| index_o | output | 21 | Remapped element index |
| illegal_o | output | 1 | Captured shape word is reserved |

## Verification
Permutations 1, 3, 4 and 5 all carry into a different dimension at a different step. A wrong order table produces sequences that match the correct one for the first element and then split off at the first carry, so the checks sample right after each carry point. The bench runs past the total element count, which catches a design that stops, saturates, or overflows instead of wrapping to 0. It also covers the all-zero word and the words with reserved bits or permutations. A design without a special case for these would stay stuck at index 0 or produce a remapped sequence where the plain step count is expected.

// File: rtl/elem_remap.sv
module elem_remap #(
  parameter int DIM_W = 7,
  parameter int IDX_W = 3 * DIM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             step_i,
  input  logic [31:0]      cfg_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] index_o,
  output logic             illegal_o
);
  localparam int FLD      = DIM_W + 1;
  localparam int PERM_LSB = 3 * FLD;

  function automatic logic [31:0] rsv_mask();
    logic [31:0] m;
    m = '1;
    m[0 +: DIM_W]        = '0;
    m[FLD +: DIM_W]      = '0;
    m[2 * FLD +: DIM_W]  = '0;
    m[PERM_LSB +: 3]     = '0;
    return m;
  endfunction

  localparam logic [31:0] RSV = rsv_mask();

  logic [31:0]      cfg_q;
  logic [DIM_W-1:0] cx, cy, cz;
  logic [IDX_W-1:0] lin;
  logic [1:0]       f_dim, m_dim, s_dim;
  logic [2:0]       at_max, en;

  wire [DIM_W-1:0] fx   = cfg_q[0 +: DIM_W];
  wire [DIM_W-1:0] fy   = cfg_q[FLD +: DIM_W];
  wire [DIM_W-1:0] fz   = cfg_q[2 * FLD +: DIM_W];
  wire [2:0]       perm = cfg_q[PERM_LSB +: 3];

  wire bad   = (|(cfg_q & RSV)) | (perm > 3'd5);
  wire ident = bad | (cfg_q == '0);
  wire adv   = valid_o & step_i & ~start_i;

  assign at_max = {cz == fz, cy == fy, cx == fx};

  always_comb begin
    case (perm)
      3'd1:    {f_dim, m_dim, s_dim} = {2'd0, 2'd2, 2'd1};
      3'd2:    {f_dim, m_dim, s_dim} = {2'd1, 2'd0, 2'd2};
      3'd3:    {f_dim, m_dim, s_dim} = {2'd1, 2'd2, 2'd0};
      3'd4:    {f_dim, m_dim, s_dim} = {2'd2, 2'd0, 2'd1};
      3'd5:    {f_dim, m_dim, s_dim} = {2'd2, 2'd1, 2'd0};
      default: {f_dim, m_dim, s_dim} = {2'd0, 2'd1, 2'd2};
    endcase
    en        = '0;
    en[f_dim] = 1'b1;
    en[m_dim] = at_max[f_dim];
    en[s_dim] = at_max[f_dim] & at_max[m_dim];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      cfg_q   <= '0;
      cx      <= '0;
      cy      <= '0;
      cz      <= '0;
      lin     <= '0;
    end else if (start_i) begin
      valid_o <= 1'b1;
      cfg_q   <= cfg_i;
      cx      <= '0;
      cy      <= '0;
      cz      <= '0;
      lin     <= '0;
    end else if (adv) begin
      lin <= lin + 1'b1;
      if (en[0]) cx <= at_max[0] ? '0 : cx + 1'b1;
      if (en[1]) cy <= at_max[1] ? '0 : cy + 1'b1;
      if (en[2]) cz <= at_max[2] ? '0 : cz + 1'b1;
    end
  end

  wire [IDX_W-1:0] xs    = IDX_W'(fx) + 1'b1;
  wire [IDX_W-1:0] ys    = IDX_W'(fy) + 1'b1;
  wire [IDX_W-1:0] remap = IDX_W'(cx) + IDX_W'(cy) * xs + IDX_W'(cz) * xs * ys;

  assign index_o   = ident ? lin : remap;
  assign illegal_o = bad;
endmodule

// File: rtl/elem_remap_chk.sv
module elem_remap_chk #(
  parameter int DIM_W = 7,
  parameter int IDX_W = 3 * DIM_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             step_i,
  input logic [31:0]      cfg_i,
  input logic             valid_o,
  input logic [IDX_W-1:0] index_o,
  input logic             illegal_o
);
  localparam int FLD = DIM_W + 1;
  logic [31:0] cap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cap <= '0;
    else if (start_i) cap <= cfg_i;

  wire [IDX_W-1:0] total = (IDX_W'(cap[0 +: DIM_W]) + 1'b1) *
                           (IDX_W'(cap[FLD +: DIM_W]) + 1'b1) *
                           (IDX_W'(cap[2 * FLD +: DIM_W]) + 1'b1);

  assert_start_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o && index_o == '0));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !start_i && !step_i) |=> $stable(index_o));

  assert_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !illegal_o && cap != '0) |-> (index_o < total));

  assert_illegal_perm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && cfg_i[3 * FLD + 1 +: 2] == 2'b11) |=> illegal_o);

  assert_identity_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && illegal_o && step_i && !start_i) |=> (index_o == $past(index_o) + 1'b1));

  assert_no_valid_before_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && !start_i) |=> !valid_o);
endmodule

bind elem_remap elem_remap_chk #(.DIM_W(DIM_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .step_i(step_i), .cfg_i(cfg_i),
  .valid_o(valid_o), .index_o(index_o), .illegal_o(illegal_o));

// File: tb/elem_remap_bench.sv
module elem_remap_bench;
  localparam int IDX_W = 21;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, step_i = 1'b0;
  logic [31:0] cfg_i = '0;
  logic valid_o, illegal_o;
  logic [IDX_W-1:0] index_o;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  elem_remap u_elem_remap (.clk(clk), .rst_n(rst_n), .start_i(start_i), .step_i(step_i),
    .cfg_i(cfg_i), .valid_o(valid_o), .index_o(index_o), .illegal_o(illegal_o));

  typedef struct packed {
    logic [31:0] cfg;
    logic [15:0] k;
    logic [23:0] exp;
    logic        ill;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    '{32'h0204_0302, 16'd1,   24'd3,   1'b0, 4'd5},  // R5 y,x,z
    '{32'h0204_0302, 16'd4,   24'd1,   1'b0, 4'd5},
    '{32'h0204_0302, 16'd12,  24'd12,  1'b0, 4'd5},
    '{32'h0204_0302, 16'd13,  24'd15,  1'b0, 4'd5},
    '{32'h0004_0302, 16'd59,  24'd59,  1'b0, 4'd7},  // R7 x,y,z linear
    '{32'h0004_0302, 16'd61,  24'd1,   1'b0, 4'd6},  // R6 wrap
    '{32'h0504_0302, 16'd1,   24'd12,  1'b0, 4'd5},
    '{32'h0504_0302, 16'd5,   24'd3,   1'b0, 4'd5},
    '{32'h0504_0302, 16'd20,  24'd1,   1'b0, 4'd5},
    '{32'h0404_0302, 16'd5,   24'd1,   1'b0, 4'd5},
    '{32'h0404_0302, 16'd15,  24'd3,   1'b0, 4'd5},
    '{32'h0104_0302, 16'd3,   24'd12,  1'b0, 4'd5},
    '{32'h0104_0302, 16'd15,  24'd3,   1'b0, 4'd5},
    '{32'h0304_0302, 16'd4,   24'd12,  1'b0, 4'd5},
    '{32'h0304_0302, 16'd20,  24'd1,   1'b0, 4'd5},
    '{32'h0000_0000, 16'd200, 24'd200, 1'b0, 4'd8},  // R8 all zero
    '{32'h0604_0302, 16'd7,   24'd7,   1'b1, 4'd9},  // R9 perm 6
    '{32'h0704_0302, 16'd3,   24'd3,   1'b1, 4'd9},  // R9 perm 7
    '{32'h0004_0382, 16'd5,   24'd5,   1'b1, 4'd9},  // R9 bit 7
    '{32'h8004_0302, 16'd2,   24'd2,   1'b1, 4'd9},  // R9 bit 31
    '{32'h0509_0000, 16'd3,   24'd3,   1'b0, 4'd4},  // R4 two unit dims
    '{32'h0509_0000, 16'd10,  24'd0,   1'b0, 4'd6},  // R6
    '{32'h0000_0001, 16'd2,   24'd0,   1'b0, 4'd4}   // R4 size = field+1
  };

  task automatic chk(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic do_start(input logic [31:0] c);
    cfg_i = c; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic do_steps(input int n);
    if (n > 0) begin
      step_i = 1'b1;
      repeat (n) @(negedge clk);
      step_i = 1'b0;
    end
  endtask

  function automatic int ref_idx(input int xd, input int yd, input int zd,
                                 input int perm, input int k);
    int c[3], lim[3], ord[3];
    lim = '{xd, yd, zd};
    c = '{0, 0, 0};
    case (perm)
      1: ord = '{0, 2, 1};
      2: ord = '{1, 0, 2};
      3: ord = '{1, 2, 0};
      4: ord = '{2, 0, 1};
      5: ord = '{2, 1, 0};
      default: ord = '{0, 1, 2};
    endcase
    for (int s = 0; s < k; s++) begin
      logic carry;
      carry = 1'b1;
      for (int j = 0; j < 3; j++) begin
        if (carry) begin
          c[ord[j]]++;
          if (c[ord[j]] == lim[ord[j]]) c[ord[j]] = 0;
          else carry = 1'b0;
        end
      end
    end
    return c[0] + c[1] * xd + c[2] * xd * yd;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", valid_o, 0);
    chk("R1 illegal", illegal_o, 0);
    chk("R1 index", index_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    do_steps(3);
    chk("R10 step before start", valid_o, 0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", TBL[i].req, i);
      do_start(TBL[i].cfg);
      chk({tag, " first"}, index_o, 0);
      do_steps(int'(TBL[i].k));
      chk(tag, index_o, TBL[i].exp);
      chk({tag, " flag"}, illegal_o, TBL[i].ill);
    end

    // R5 R6 R7 full sweep of every legal order past one wrap
    for (int p = 0; p < 6; p++) begin
      do_start(32'h0004_0302 | (p << 24));
      for (int k = 0; k < 66; k++) begin
        chk($sformatf("R5 perm%0d k%0d", p, k), index_o, ref_idx(3, 4, 5, p, k));
        do_steps(1);
      end
    end

    // R3 hold without step
    do_start(32'h0204_0302);
    do_steps(1);
    repeat (4) @(negedge clk);
    chk("R3 hold", index_o, 3);
    do_steps(1);
    chk("R3 advance", index_o, 6);

    // R2 restart mid walk, start wins over step
    step_i = 1'b1;
    do_start(32'h0504_0302);
    step_i = 1'b0;
    chk("R2 restart", index_o, 0);
    chk("R2 valid", valid_o, 1);
    do_steps(1);
    chk("R2 new cfg", index_o, 12);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule